// File: doc/BRIEF.md
# Microprogram Sequencer for a Multi-Cycle Controller

This block is the next-state engine of a multi-cycle processor controller. It holds a 4-bit state number and a small constant microprogram that holds one control word per state. Each control word carries a 2-bit sequencing field, which picks the next state from one of three sources. The first source is the constant zero, which is the fetch state. The second is a lookup on the instruction opcode. The third is the current state plus one. Because the states of each instruction are numbered in a row, one incrementer and one opcode lookup replace a general transition function.

The surrounding datapath gives the 6-bit opcode and the branch-equal condition. It receives the current state number and a 13-bit control word. The branch PC-write bit of that word is qualified by the condition. The reset is asynchronous and active low. Its release is synchronised, and the sequencer leaves state 0 on the third rising edge after `rst_n` goes high.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `state_num` is 0 and `ctrl_word` is 13'h007. After `rst_n` rises, the state stays 0 through two rising edges and moves to 1 on the third.
- R2: State 0 (fetch) always goes to state 1 on the next edge.
- R3: State 1 (decode) goes to a state chosen by the opcode: 6'h00 goes to 4, 6'h0D goes to 6, 6'h23 goes to 8, 6'h2B goes to 11 and 6'h04 goes to 2. Any other opcode goes to 0.
- R4: States 0, 4, 6, 8, 9 and 11 go to the state plus one. This gives the paths 4→5, 6→7, 8→9→10 and 11→12.
- R5: States 2, 5, 7, 10 and 12 return to state 0 on the next edge.
- R6: The fetch and memory bits of the control word are bit0 pc_load, bit1 ir_load, bit2 mem_read, bit3 mem_write and bit11 addr_from_alu. Bits 0 to 2 are set only in state 0. Bits 2 and 11 are set in state 9. Bits 3 and 11 are set in state 12.
- R7: The register-file bits are bit4 reg_write, bit5 wb_mem and bit6 dst_rd. Bits 4 and 6 are set in state 5, bit 4 alone in state 7, and bits 4 and 5 in state 10. These bits are clear in every other state.
- R8: The ALU bits are bit7 b_imm, bit8 imm_sign and bits 10:9 alu_mode, where 00 is add, 01 is sub, 10 is or and 11 means decode the function field. State 2 uses sub. State 4 uses 11. State 6 uses or with b_imm. States 8 and 11 use add with b_imm and imm_sign. All other states use 0.
- R9: Bit 12 (branch PC write) equals `cond` in state 2 and is 0 in every other state.
- R10: The opcode has no effect on the next state in any state other than 1.
- R11: Pulling `rst_n` low in the middle of an instruction forces state 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Instruction opcode, used only in the decode state |
| cond | input | 1 | Branch-equal condition from the datapath |
| state_num | output | 4 | Current state number |
| ctrl_word | output | 13 | Datapath control word for the current state |

## Verification
The bench goes after the decode lookup. A wrong table entry, or an unknown opcode that does not fall back to 0, sends a path into the wrong state, and the per-cycle state check sees it at once. It changes the opcode randomly in non-decode states, so a design that reads the opcode outside decode leaves the expected path. It also drives both values of the branch condition in the branch state and outside it, so a design with an ungated branch write, or one that returns too early or too late from the last state of a path, reports a mismatch. Finally, it checks the two-edge reset release and a reset in the middle of a path. A design with a missing synchroniser stage moves one cycle too early, and a design with a synchronous-only reset holds a stale state.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int STATE_BITS = 4;
  localparam int OP_BITS    = 6;
  localparam int CTRL_BITS  = 13;

  // sequencing field of a microword
  typedef enum logic [1:0] {
    SEQ_ZERO = 2'b00,
    SEQ_DISP = 2'b01,
    SEQ_INC  = 2'b10,
    SEQ_RSVD = 2'b11
  } seq_kind_e;

  // control word, MSB first: bit12 .. bit0
  typedef struct packed {
    logic       pc_branch;
    logic       addr_from_alu;
    logic [1:0] alu_mode;
    logic       imm_sign;
    logic       b_imm;
    logic       dst_rd;
    logic       wb_mem;
    logic       reg_write;
    logic       mem_write;
    logic       mem_read;
    logic       ir_load;
    logic       pc_load;
  } ctrl_t;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_OR   = 2'b10;
  localparam logic [1:0] ALU_FUNC = 2'b11;

  // opcodes
  localparam logic [OP_BITS-1:0] OPC_REG   = 6'h00;
  localparam logic [OP_BITS-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_BITS-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OP_BITS-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_BITS-1:0] OPC_STORE = 6'h2B;

  // state numbers; each path is consecutive
  localparam logic [STATE_BITS-1:0] ST_FETCH   = 4'd0;
  localparam logic [STATE_BITS-1:0] ST_DECODE  = 4'd1;
  localparam logic [STATE_BITS-1:0] ST_BEQ     = 4'd2;
  localparam logic [STATE_BITS-1:0] ST_REG_EX  = 4'd4;
  localparam logic [STATE_BITS-1:0] ST_REG_WB  = 4'd5;
  localparam logic [STATE_BITS-1:0] ST_ORI_EX  = 4'd6;
  localparam logic [STATE_BITS-1:0] ST_ORI_WB  = 4'd7;
  localparam logic [STATE_BITS-1:0] ST_LD_ADR  = 4'd8;
  localparam logic [STATE_BITS-1:0] ST_LD_MEM  = 4'd9;
  localparam logic [STATE_BITS-1:0] ST_LD_WB   = 4'd10;
  localparam logic [STATE_BITS-1:0] ST_ST_ADR  = 4'd11;
  localparam logic [STATE_BITS-1:0] ST_ST_MEM  = 4'd12;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[i] <= 1'b0;
        end else begin
          if (i == 0) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
        end
      end
    end
  endgenerate

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int SW = STATE_BITS,
  parameter int OW = OP_BITS
) (
  input  logic [OW-1:0] opcode,
  output logic [SW-1:0] target
);
  always_comb begin
    case (opcode)
      OPC_REG:   target = ST_REG_EX;
      OPC_ORI:   target = ST_ORI_EX;
      OPC_LOAD:  target = ST_LD_ADR;
      OPC_STORE: target = ST_ST_ADR;
      OPC_BEQ:   target = ST_BEQ;
      default:   target = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/useq_ctrl_rom.sv
module useq_ctrl_rom
  import useq_pkg::*;
#(
  parameter int SW = STATE_BITS
) (
  input  logic [SW-1:0] state,
  output ctrl_t         word,
  output seq_kind_e     kind
);
  always_comb begin
    word = '0;
    kind = SEQ_RSVD;
    case (state)
      ST_FETCH: begin
        word.pc_load  = 1'b1;
        word.ir_load  = 1'b1;
        word.mem_read = 1'b1;
        kind          = SEQ_INC;
      end
      ST_DECODE: kind = SEQ_DISP;
      ST_BEQ: begin
        word.alu_mode  = ALU_SUB;
        word.pc_branch = 1'b1;
        kind           = SEQ_ZERO;
      end
      ST_REG_EX: begin
        word.alu_mode = ALU_FUNC;
        kind          = SEQ_INC;
      end
      ST_REG_WB: begin
        word.reg_write = 1'b1;
        word.dst_rd    = 1'b1;
        kind           = SEQ_ZERO;
      end
      ST_ORI_EX: begin
        word.alu_mode = ALU_OR;
        word.b_imm    = 1'b1;
        kind          = SEQ_INC;
      end
      ST_ORI_WB: begin
        word.reg_write = 1'b1;
        kind           = SEQ_ZERO;
      end
      ST_LD_ADR, ST_ST_ADR: begin
        word.alu_mode = ALU_ADD;
        word.b_imm    = 1'b1;
        word.imm_sign = 1'b1;
        kind          = SEQ_INC;
      end
      ST_LD_MEM: begin
        word.mem_read      = 1'b1;
        word.addr_from_alu = 1'b1;
        kind               = SEQ_INC;
      end
      ST_LD_WB: begin
        word.reg_write = 1'b1;
        word.wb_mem    = 1'b1;
        kind           = SEQ_ZERO;
      end
      ST_ST_MEM: begin
        word.mem_write     = 1'b1;
        word.addr_from_alu = 1'b1;
        kind               = SEQ_ZERO;
      end
      default: kind = SEQ_RSVD;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int SW = STATE_BITS
) (
  input  logic [SW-1:0] cur,
  input  seq_kind_e     kind,
  input  logic [SW-1:0] disp_target,
  output logic [SW-1:0] nxt
);
  logic [SW-1:0] inc;

  assign inc = cur + {{(SW-1){1'b0}}, 1'b1};

  always_comb begin
    case (kind)
      SEQ_DISP: nxt = disp_target;
      SEQ_INC:  nxt = inc;
      default:  nxt = '0;   // zero and reserved code both restart fetch
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int SW   = STATE_BITS,
  parameter int OW   = OP_BITS,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OW-1:0]        opcode,
  input  logic                 cond,
  output logic [SW-1:0]        state_num,
  output logic [CTRL_BITS-1:0] ctrl_word
);
  logic          rst_ok;
  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  logic [SW-1:0] disp_target;
  ctrl_t         raw_word;
  ctrl_t         out_word;
  seq_kind_e     kind;

  useq_rst_sync #(.STAGES(SYNC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  useq_ctrl_rom #(.SW(SW)) u_rom (
    .state (state_q),
    .word  (raw_word),
    .kind  (kind)
  );

  useq_dispatch #(.SW(SW), .OW(OW)) u_disp (
    .opcode (opcode),
    .target (disp_target)
  );

  useq_next #(.SW(SW)) u_next (
    .cur         (state_q),
    .kind        (kind),
    .disp_target (disp_target),
    .nxt         (state_d)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) state_q <= '0;
    else         state_q <= state_d;
  end

  always_comb begin
    out_word           = raw_word;
    out_word.pc_branch = raw_word.pc_branch & cond;
  end

  assign state_num = state_q;
  assign ctrl_word = out_word;

  // R2
  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_ok)
    state_q == ST_FETCH |=> state_q == ST_DECODE);

  // R3
  a_r3_dispatch_legal: assert property (@(posedge clk) disable iff (!rst_ok)
    state_q == ST_DECODE |=> (state_q == ST_FETCH || state_q == ST_BEQ ||
      state_q == ST_REG_EX || state_q == ST_ORI_EX ||
      state_q == ST_LD_ADR || state_q == ST_ST_ADR));

  // R4
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_LD_ADR || state_q == ST_LD_MEM || state_q == ST_ST_ADR ||
     state_q == ST_REG_EX || state_q == ST_ORI_EX)
    |=> state_q == $past(state_q) + 4'd1);

  // R5
  a_r5_path_end: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_BEQ || state_q == ST_REG_WB || state_q == ST_ORI_WB ||
     state_q == ST_LD_WB || state_q == ST_ST_MEM) |=> state_q == ST_FETCH);

  // R6
  a_r6_store_only: assert property (@(posedge clk) disable iff (!rst_ok)
    ctrl_word[3] |-> state_num == ST_ST_MEM);

  // R9
  a_r9_branch_in_beq: assert property (@(posedge clk) disable iff (!rst_ok)
    ctrl_word[12] |-> (state_num == ST_BEQ && cond));
endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  opcode;
  logic        cond;
  logic [3:0]  state_num;
  logic [12:0] ctrl_word;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [3:0] e;

  useq_top dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .cond(cond),
    .state_num(state_num), .ctrl_word(ctrl_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // 0 zero, 1 dispatch, 2 increment
  function automatic int kind_of(logic [3:0] s);
    case (s)
      4'd0, 4'd4, 4'd6, 4'd8, 4'd9, 4'd11: return 2;
      4'd1: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] model_next(logic [3:0] s, logic [5:0] op);
    case (kind_of(s))
      2: return s + 4'd1;
      1: case (op)
           6'h00: return 4'd4;
           6'h0D: return 4'd6;
           6'h23: return 4'd8;
           6'h2B: return 4'd11;
           6'h04: return 4'd2;
           default: return 4'd0;
         endcase
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [12:0] exp_ctrl(logic [3:0] s, logic c);
    case (s)
      4'd0:  return 13'h0007;
      4'd2:  return {c, 12'h200};
      4'd4:  return 13'h0600;
      4'd5:  return 13'h0050;
      4'd6:  return 13'h0480;
      4'd7:  return 13'h0010;
      4'd8, 4'd11: return 13'h0180;
      4'd9:  return 13'h0804;
      4'd10: return 13'h0030;
      4'd12: return 13'h0808;
      default: return 13'h0000;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ctrl(logic c);
    logic [12:0] x;
    x = exp_ctrl(e, c);
    chk("R6 fetch/memory bits", 16'(ctrl_word & 13'h080F), 16'(x & 13'h080F));
    chk("R7 register bits",     16'(ctrl_word & 13'h0070), 16'(x & 13'h0070));
    chk("R8 alu bits",          16'(ctrl_word & 13'h0780), 16'(x & 13'h0780));
    chk("R9 branch bit",        16'(ctrl_word[12]), 16'(x[12]));
  endtask

  // one clock: drive inputs, check word, step, check state
  task automatic cycle(logic [5:0] op, logic c, bit scramble);
    logic [3:0] prev;
    opcode = op;
    cond   = c;
    #1;
    chk_ctrl(c);
    prev = e;
    @(posedge clk);
    #1;
    e = model_next(prev, op);
    if (scramble && prev != 4'd1)      chk("R10 opcode ignored", 16'(state_num), 16'(e));
    else if (prev == 4'd0)             chk("R2 fetch->decode", 16'(state_num), 16'(e));
    else if (prev == 4'd1)             chk("R3 dispatch", 16'(state_num), 16'(e));
    else if (kind_of(prev) == 2)       chk("R4 increment", 16'(state_num), 16'(e));
    else                               chk("R5 return to fetch", 16'(state_num), 16'(e));
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      #1;
      chk("R1 held during release", 16'(state_num), 16'd0);
    end
    e = 4'd0;
  endtask

  // one instruction from fetch back to fetch
  task automatic run_instr(logic [5:0] op, logic c, bit scramble);
    int n = 0;
    cycle(op, c, 0);            // fetch
    cycle(op, c, 0);            // decode
    while (e != 4'd0 && n < 8) begin
      cycle(scramble ? 6'($urandom) : op, c, scramble);
      n++;
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    rst_n  = 1'b0;
    opcode = 6'h23;
    cond   = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset state", 16'(state_num), 16'd0);
    chk("R1 reset word", 16'(ctrl_word), 16'h0007);
    release_reset();
    e = 4'd0;
    cycle(6'h00, 1'b0, 0);
    chk("R1 first move", 16'(state_num), 16'd1);
    e = 4'd1;
    cycle(6'h3F, 1'b0, 0);      // unknown opcode -> fetch

    // directed paths
    run_instr(6'h00, 1'b0, 0);
    run_instr(6'h0D, 1'b1, 0);
    run_instr(6'h23, 1'b0, 0);
    run_instr(6'h2B, 1'b1, 0);
    run_instr(6'h04, 1'b1, 0);
    run_instr(6'h04, 1'b0, 0);
    run_instr(6'h11, 1'b1, 0);
    run_instr(6'h23, 1'b1, 1);
    run_instr(6'h2B, 1'b0, 1);
    run_instr(6'h00, 1'b1, 1);

    // reset in the middle of a load
    cycle(6'h23, 1'b0, 0);
    cycle(6'h23, 1'b0, 0);
    cycle(6'h23, 1'b0, 0);
    chk("R11 reached state 9", 16'(state_num), 16'd9);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R11 immediate reset", 16'(state_num), 16'd0);
    chk("R1 word in reset", 16'(ctrl_word), 16'h0007);
    release_reset();

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] op;
      case ($urandom % 8)
        0: op = 6'h00;
        1: op = 6'h0D;
        2: op = 6'h23;
        3: op = 6'h2B;
        4: op = 6'h04;
        default: op = 6'($urandom);
      endcase
      cycle(op, 1'($urandom), 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule